// File: doc/BRIEF.md
# T1 Receive Alarm and Interrupt Monitor

This block watches the receive side of a T1 line after framing recovery. Each received bit arrives with a line-bit strobe together with its two rail values and its decoded data bit. Side strobes mark the framing-bit slot, the bit position inside a channel word and the S-bit of frame 12. The block turns this stream into alarm conditions: carrier loss, the all-ones alarm indication signal (blue), the remote yellow alarm, framing-bit errors, out-of-frame, and a loss-of-sync flag that stays raised until the frame search logic reports that sync was found.

The alarm conditions are kept in a status vector with sticky bits. Three saturating counters count bipolar violations, framing-bit errors and out-of-frame entries. A single interrupt line is formed from the status bits that the host has enabled in a mask. Alarm bits and counter-saturation bits follow different clear rules. An alarm bit is cleared by a plain status read unless its condition is still present. A saturation bit is cleared only when the host writes a non-saturated value into that counter.

Top module: `t1_rx_alarm_mon`

## Requirements
- R1: Status bit 0 (carrier loss) sets once 32 consecutive line bits (`bit_en` high) have both `rpos` and `rneg` at 0. A line bit with a mark on either rail restarts the run.
- R2: Status bit 1 (blue) is evaluated at each framing bit. It is 1 when the two most recent complete frames together hold fewer than three 0s on `rdat`, with framing-bit slots excluded. No result is given until two complete frames have been seen after reset.
- R3: Status bit 2 (yellow). With `yel_mode`=0 it is evaluated at each framing bit and is 1 when no bit with `chan_bit`=1 (the second bit of a channel word) was 1 in the frame just ended. With `yel_mode`=1 it takes the value of `rdat` at a framing bit marked by `s12`, and other framing bits leave it unchanged.
- R4: A framing-bit check with an error (`fb_chk` and `fb_err`) sets status bit 3 and increments the 4-bit count `fec`.
- R5: Status bit 4 (out-of-frame) is 1 while at least 2 of the last 4 checked framing bits (`oof_win5`=0) or 2 of the last 5 (`oof_win5`=1) were in error. Each entry into out-of-frame increments the 4-bit count `ofc`.
- R6: With `auto_resync`=1, out-of-frame or carrier loss raises status bit 5 (loss of sync). The bit stays raised until `sync_found`, which also empties the framing-error history. With `auto_resync`=0 it does not rise.
- R7: `bvc` counts `bpv` strobes and saturates at 255. Status bit 6 is 1 while it is saturated.
- R8: Status bit 7 is 1 while `fec` or `ofc` is saturated at 15.
- R9: A counter write strobe loads `wr_data` into that counter and takes priority over an increment in the same cycle. Saturation bits ignore status reads and clear only through a write of a value that is not all ones.
- R10: Status bits 0 to 5 are sticky. A status read with `st_burst`=0 clears them unless their condition is still present. A read with `st_burst`=1 leaves them unchanged.
- R11: `irq` is high exactly when some status bit is 1 and its `mask` bit is 1. Clearing the mask bit removes the interrupt without touching the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One received line bit this cycle |
| rpos | input | 1 | Positive rail mark |
| rneg | input | 1 | Negative rail mark |
| rdat | input | 1 | Decoded data bit |
| fbit | input | 1 | Current bit is the framing-bit slot |
| chan_bit | input | 3 | Bit position inside the channel word, 0 = first |
| s12 | input | 1 | Current framing bit is the S-bit of frame 12 |
| yel_mode | input | 1 | Yellow detection select (see R3) |
| fb_chk | input | 1 | A framing bit was checked this cycle |
| fb_err | input | 1 | The checked framing bit was wrong |
| oof_win5 | input | 1 | Out-of-frame window: 0 = 2 of 4, 1 = 2 of 5 |
| auto_resync | input | 1 | Allow automatic loss-of-sync |
| sync_found | input | 1 | Frame search reports sync |
| bpv | input | 1 | Bipolar violation strobe |
| st_rd | input | 1 | Host status read strobe |
| st_burst | input | 1 | The read is part of a burst |
| bvc_wr | input | 1 | Write `wr_data` into `bvc` |
| fec_wr | input | 1 | Write `wr_data[3:0]` into `fec` |
| ofc_wr | input | 1 | Write `wr_data[3:0]` into `ofc` |
| wr_data | input | 8 | Host counter write value |
| mask | input | 8 | Interrupt enable per status bit |
| status | output | 8 | Status vector |
| bvc | output | 8 | Bipolar violation count |
| fec | output | 4 | Framing-bit error count |
| ofc | output | 4 | Out-of-frame entry count |
| irq | output | 1 | Interrupt request |

## Verification
Blue and yellow are driven with random frames. Each frame carries between zero and four scattered zeros, and some frames have the second bit of every channel cleared. This separates a one-frame zero count from a two-frame count, and separates the blue rule from the second-bit yellow rule. The zero runs stop at 31 and at 32 bits, and one run is broken by a mark on the negative rail, to pin the carrier-loss threshold. The error patterns E,-,-,E and E,-,-,-,E distinguish the 4-bit window from the 5-bit window. Reads with and without the burst flag, and counter writes of all ones against a non-saturated value, tell the alarm clear rules apart from the saturation clear rules.

// File: rtl/t1am_pkg.sv
// Shared layout of the status vector for the T1 receive alarm monitor.
// Assumes: status bits below ST_NDIR are sticky alarm bits, the rest are
// level bits driven from counter saturation.
package t1am_pkg;
    localparam int ST_W    = 8;
    localparam int ST_CL   = 0;   // carrier loss
    localparam int ST_BLUE = 1;   // alarm indication signal
    localparam int ST_YEL  = 2;   // remote yellow
    localparam int ST_FERR = 3;   // framing bit error
    localparam int ST_OOF  = 4;   // out of frame
    localparam int ST_LOS  = 5;   // loss of sync
    localparam int ST_BVS  = 6;   // violation count saturated
    localparam int ST_ECS  = 7;   // error count saturated
    localparam int ST_NDIR = 6;   // number of sticky alarm bits
endpackage

// File: rtl/t1am_sat_cnt.sv
// Saturating event counter with host load.
// Assumes: a load takes priority over an increment in the same cycle.
module t1am_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cnt,
    output logic         full
);
    assign full = &cnt;

    // Load, count up, or hold at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr)
            cnt <= wr_val;
        else if (inc && !full)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/t1am_line_mon.sv
// Carrier loss detector: counts line bits with no mark on either rail.
// Assumes: bit_en qualifies rpos/rneg; idle cycles neither count nor reset.
module t1am_line_mon #(
    parameter int CL_ZEROS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rpos,
    input  logic rneg,
    output logic cl_now
);
    localparam int CW = $clog2(CL_ZEROS + 1);
    localparam logic [CW-1:0] CL_V = CW'(CL_ZEROS);

    logic [CW-1:0] zrun;

    // Length of the current space run, held at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zrun <= '0;
        else if (bit_en) begin
            if (rpos || rneg)
                zrun <= '0;
            else if (zrun != CL_V)
                zrun <= zrun + 1'b1;
        end
    end

    assign cl_now = (zrun == CL_V);
endmodule

// File: rtl/t1am_frame_mon.sv
// Per-frame alarm detection: blue (too few zeros over two frames) and
// yellow (second channel bit low everywhere, or the frame-12 S-bit).
// Assumes: a framing bit closes the frame made of the bits before it, and
// the first framing bit after reset closes a partial frame.
module t1am_frame_mon #(
    parameter int BLUE_MAX_Z = 2,
    parameter int YBIT       = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       fbit,
    input  logic       rdat,
    input  logic [2:0] chan_bit,
    input  logic       s12,
    input  logic       yel_mode,
    output logic       blue_now,
    output logic       yel_now
);
    localparam int ZW = $clog2(BLUE_MAX_Z + 2);
    localparam logic [ZW-1:0] ZMAX = ZW'(BLUE_MAX_Z + 1);

    logic [ZW-1:0] cur_z, prev_z;
    logic [ZW:0]   zsum;
    logic [1:0]    nfr;
    logic          b2_one, yb_q, ys_q;

    assign zsum = {1'b0, prev_z} + {1'b0, cur_z};

    // Zero counting, frame closing and alarm evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_z    <= '0;
            prev_z   <= '0;
            nfr      <= '0;
            b2_one   <= 1'b0;
            blue_now <= 1'b0;
            yb_q     <= 1'b0;
            ys_q     <= 1'b0;
        end else if (bit_en) begin
            if (fbit) begin
                prev_z   <= cur_z;
                cur_z    <= '0;
                nfr      <= (nfr == 2'd3) ? nfr : nfr + 1'b1;
                blue_now <= (nfr >= 2'd2) && (zsum <= (ZW+1)'(BLUE_MAX_Z));
                yb_q     <= (nfr != 2'd0) && !b2_one;
                b2_one   <= 1'b0;
                if (s12)
                    ys_q <= rdat;
            end else begin
                if (!rdat && cur_z != ZMAX)
                    cur_z <= cur_z + 1'b1;
                if (rdat && chan_bit == 3'(YBIT))
                    b2_one <= 1'b1;
            end
        end
    end

    assign yel_now = yel_mode ? ys_q : yb_q;
endmodule

// File: rtl/t1am_oof_mon.sv
// Out-of-frame detector over a sliding window of framing-bit check results.
// Assumes: sync_found empties the history so a new alignment starts clean.
module t1am_oof_mon #(
    parameter int HIST     = 5,
    parameter int OOF_ERRS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_chk,
    input  logic fb_err,
    input  logic win_long,
    input  logic sync_found,
    output logic oof_now
);
    logic [HIST-1:0] hist;

    // Shift in one result per checked framing bit.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_found)
            hist <= '0;
        else if (fb_chk)
            hist <= {hist[HIST-2:0], fb_err};
    end

    // Error threshold over the long or the short window.
    always_comb begin
        if (win_long)
            oof_now = ($countones(hist) >= OOF_ERRS);
        else
            oof_now = ($countones(hist[HIST-2:0]) >= OOF_ERRS);
    end
endmodule

// File: rtl/t1_rx_alarm_mon.sv
// T1 receive alarm and interrupt monitor: combines line, frame and
// out-of-frame detectors into sticky status, saturating counters and a
// masked interrupt.
// Assumes: host strobes are one cycle wide and synchronous to clk.
module t1_rx_alarm_mon
    import t1am_pkg::*;
#(
    parameter int CL_ZEROS   = 32,
    parameter int BLUE_MAX_Z = 2,
    parameter int OOF_HIST   = 5,
    parameter int BV_W       = 8,
    parameter int EC_W       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            rpos,
    input  logic            rneg,
    input  logic            rdat,
    input  logic            fbit,
    input  logic [2:0]      chan_bit,
    input  logic            s12,
    input  logic            yel_mode,
    input  logic            fb_chk,
    input  logic            fb_err,
    input  logic            oof_win5,
    input  logic            auto_resync,
    input  logic            sync_found,
    input  logic            bpv,
    input  logic            st_rd,
    input  logic            st_burst,
    input  logic            bvc_wr,
    input  logic            fec_wr,
    input  logic            ofc_wr,
    input  logic [BV_W-1:0] wr_data,
    input  logic [ST_W-1:0] mask,
    output logic [ST_W-1:0] status,
    output logic [BV_W-1:0] bvc,
    output logic [EC_W-1:0] fec,
    output logic [EC_W-1:0] ofc,
    output logic            irq
);
    logic cl_now, blue_now, yel_now, oof_now;
    logic oof_d, los, rd_clr;
    logic bv_full, fe_full, of_full;
    logic [ST_NDIR-1:0] cond, sticky;

    t1am_line_mon #(.CL_ZEROS(CL_ZEROS)) u_line (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .rpos(rpos), .rneg(rneg), .cl_now(cl_now)
    );

    t1am_frame_mon #(.BLUE_MAX_Z(BLUE_MAX_Z), .YBIT(1)) u_frame (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fbit(fbit),
        .rdat(rdat), .chan_bit(chan_bit), .s12(s12), .yel_mode(yel_mode),
        .blue_now(blue_now), .yel_now(yel_now)
    );

    t1am_oof_mon #(.HIST(OOF_HIST), .OOF_ERRS(2)) u_oof (
        .clk(clk), .rst_n(rst_n), .fb_chk(fb_chk), .fb_err(fb_err),
        .win_long(oof_win5), .sync_found(sync_found), .oof_now(oof_now)
    );

    t1am_sat_cnt #(.W(BV_W)) u_bvc (
        .clk(clk), .rst_n(rst_n), .inc(bpv), .wr(bvc_wr),
        .wr_val(wr_data), .cnt(bvc), .full(bv_full)
    );

    t1am_sat_cnt #(.W(EC_W)) u_fec (
        .clk(clk), .rst_n(rst_n), .inc(fb_chk && fb_err), .wr(fec_wr),
        .wr_val(wr_data[EC_W-1:0]), .cnt(fec), .full(fe_full)
    );

    t1am_sat_cnt #(.W(EC_W)) u_ofc (
        .clk(clk), .rst_n(rst_n), .inc(oof_now && !oof_d), .wr(ofc_wr),
        .wr_val(wr_data[EC_W-1:0]), .cnt(ofc), .full(of_full)
    );

    // Out-of-frame edge memory and loss-of-sync flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oof_d <= 1'b0;
            los   <= 1'b0;
        end else begin
            oof_d <= oof_now;
            if (sync_found)
                los <= 1'b0;
            else if (auto_resync && (oof_now || cl_now))
                los <= 1'b1;
        end
    end

    always_comb begin
        cond          = '0;
        cond[ST_CL]   = cl_now;
        cond[ST_BLUE] = blue_now;
        cond[ST_YEL]  = yel_now;
        cond[ST_FERR] = fb_chk && fb_err;
        cond[ST_OOF]  = oof_now;
        cond[ST_LOS]  = los;
    end

    assign rd_clr = st_rd && !st_burst;

    // Sticky alarm bits: set by the condition, cleared by a plain read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky <= '0;
        else
            sticky <= cond | (sticky & {ST_NDIR{!rd_clr}});
    end

    // Assemble status; saturation bits follow the counters directly.
    always_comb begin
        status               = '0;
        status[ST_NDIR-1:0]  = sticky;
        status[ST_BVS]       = bv_full;
        status[ST_ECS]       = fe_full || of_full;
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/t1am_checker.sv
// Temporal checks for the T1 receive alarm monitor, bound to the top.
// Assumes: only port-level signals are observed.
module t1am_checker #(
    parameter int BV_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bpv,
    input logic            bvc_wr,
    input logic [BV_W-1:0] wr_data,
    input logic [BV_W-1:0] bvc,
    input logic            st_rd,
    input logic            st_burst,
    input logic            fb_chk,
    input logic            fb_err,
    input logic [7:0]      status,
    input logic [7:0]      mask,
    input logic            irq
);
    p_bv_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&bvc && !bvc_wr) |=> &bvc);

    p_bv_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bpv && !bvc_wr && !(&bvc)) |=> (bvc == BV_W'($past(bvc) + 1'b1)));

    p_wr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bvc_wr |=> (bvc == $past(wr_data)));

    p_burst_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && st_burst && status[3]) |=> status[3]);

    p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && !st_burst && status[3] && !(fb_chk && fb_err)) |=> !status[3]);

    p_sticky_los_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !st_rd) |=> status[5]);

    p_mask_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'h00) |-> !irq);
endmodule

bind t1_rx_alarm_mon t1am_checker #(.BV_W(BV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bpv(bpv), .bvc_wr(bvc_wr),
    .wr_data(wr_data), .bvc(bvc), .st_rd(st_rd), .st_burst(st_burst),
    .fb_chk(fb_chk), .fb_err(fb_err), .status(status), .mask(mask),
    .irq(irq)
);

// File: tb/tb_t1_rx_alarm_mon.sv
`timescale 1ns/1ps
// Bench for the T1 receive alarm monitor: random frames checked against a
// bench model, followed by directed corner cases.
module tb_t1_rx_alarm_mon;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 0, rpos = 0, rneg = 0, rdat = 0, fbit = 0, s12 = 0;
    logic [2:0] chan_bit = '0;
    logic yel_mode = 0, fb_chk = 0, fb_err = 0, oof_win5 = 0;
    logic auto_resync = 0, sync_found = 0, bpv = 0;
    logic st_rd = 0, st_burst = 0, bvc_wr = 0, fec_wr = 0, ofc_wr = 0;
    logic [7:0] wr_data = '0, mask = '0;
    logic [7:0] status, bvc;
    logic [3:0] fec, ofc;
    logic irq;

    int n_chk = 0, n_bad = 0;
    bit rnd_bpv = 0;
    int bv_exp = 0;
    int fcount = 0, z_last = 0, z_prev = 0;
    bit blue_exp = 0, yel_exp = 0;

    always #2.5 clk = ~clk;

    t1_rx_alarm_mon dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rpos(rpos), .rneg(rneg),
        .rdat(rdat), .fbit(fbit), .chan_bit(chan_bit), .s12(s12),
        .yel_mode(yel_mode), .fb_chk(fb_chk), .fb_err(fb_err),
        .oof_win5(oof_win5), .auto_resync(auto_resync),
        .sync_found(sync_found), .bpv(bpv), .st_rd(st_rd),
        .st_burst(st_burst), .bvc_wr(bvc_wr), .fec_wr(fec_wr),
        .ofc_wr(ofc_wr), .wr_data(wr_data), .mask(mask), .status(status),
        .bvc(bvc), .fec(fec), .ofc(ofc), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        bit_en = 0; fbit = 0; s12 = 0;
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic put_bit(input bit p, input bit n, input bit d,
                           input bit f, input int cb, input bit s);
        bit_en = 1; rpos = p; rneg = n; rdat = d; fbit = f;
        chan_bit = 3'(cb); s12 = s;
        bpv = rnd_bpv && ($urandom % 64 == 0);
        if (bpv && bv_exp < 255) bv_exp++;
        cyc();
        bpv = 0;
    endtask

    // 24 channel words, then the framing bit that closes the frame.
    task automatic send_frame(input int nz, input bit yb2, input bit sv, input bit s);
        for (int c = 0; c < 24; c++) begin
            int r, zb;
            r  = int'($urandom % 7);
            zb = (c < nz) ? ((r == 0) ? 0 : r + 1) : 8;
            for (int b = 0; b < 8; b++) begin
                bit d;
                d = 1;
                if (yb2 && b == 1) d = 0;
                if (b == zb) d = 0;
                put_bit(d, 0, d, 0, b, 0);
            end
        end
        put_bit(1, 0, sv, 1, 0, s);
        idle(2);
    endtask

    task automatic rd_clear();
        st_rd = 1; st_burst = 0; cyc();
        st_rd = 0; cyc();
    endtask

    task automatic fbchk(input bit e);
        fb_chk = 1; fb_err = e; cyc();
        fb_chk = 0; fb_err = 0;
    endtask

    task automatic sync_pulse();
        sync_found = 1; cyc(); sync_found = 0; idle(2); rd_clear();
    endtask

    function automatic int exp_status(input bit blue, input bit yel, input int bv);
        return (blue ? 2 : 0) | (yel ? 4 : 0) | ((bv == 255) ? 64 : 0);
    endfunction

    task automatic model_frame(input int nz, input bit yb2);
        fcount++;
        z_prev = z_last;
        z_last = nz + (yb2 ? 24 : 0);
        blue_exp = (fcount >= 3) && (z_prev + z_last < 3);
        yel_exp  = (fcount >= 2) && yb2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        idle(3);
        rst_n = 1;
        cyc();
        // reset state
        check("R10 reset status", status, 0);
        check("R7 reset bvc", bvc, 0);
        check("R4 reset fec", fec, 0);
        check("R5 reset ofc", ofc, 0);
        check("R11 reset irq", irq, 0);

        // R2/R3/R7: random frames, second-bit yellow mode
        rnd_bpv = 1;
        for (int k = 0; k < 30; k++) begin
            int nz;
            bit yb2;
            nz  = (k < 4) ? k % 2 : int'($urandom % 5);
            yb2 = ($urandom % 4 == 0);
            send_frame(nz, yb2, 0, 0);
            model_frame(nz, yb2);
            rd_clear();
            check("R2 R3 random frame status", status, exp_status(blue_exp, yel_exp, bv_exp));
            check("R7 random bvc", bvc, bv_exp);
        end
        rnd_bpv = 0;

        // R3: S-bit yellow mode
        yel_mode = 1;
        send_frame(3, 0, 1, 1); rd_clear();
        check("R3 sbit one", status[2], 1);
        send_frame(3, 1, 0, 0); rd_clear();
        check("R3 non-frame12 ignored", status[2], 1);
        send_frame(3, 0, 0, 1); rd_clear();
        check("R3 sbit zero", status[2], 0);
        check("R2 no blue with zeros", status[1], 0);

        // R1: carrier loss threshold
        for (int i = 0; i < 31; i++) put_bit(0, 0, 0, 0, 0, 0);
        idle(2); rd_clear();
        check("R1 31 zeros", status[0], 0);
        put_bit(0, 0, 0, 0, 0, 0);
        idle(2); rd_clear();
        check("R1 32 zeros", status[0], 1);
        check("R6 no los without auto", status[5], 0);
        put_bit(1, 0, 1, 0, 0, 0);
        idle(2);
        check("R10 sticky until read", status[0], 1);
        rd_clear();
        check("R10 read clears gone alarm", status[0], 0);
        for (int i = 0; i < 20; i++) put_bit(0, 0, 0, 0, 0, 0);
        put_bit(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) put_bit(0, 0, 0, 0, 0, 0);
        put_bit(1, 0, 1, 0, 0, 0);
        idle(2); rd_clear();
        check("R1 run broken by rneg", status[0], 0);

        // R4/R5/R6: out-of-frame windows and loss of sync
        auto_resync = 1; oof_win5 = 0;
        sync_pulse();
        fbchk(1); idle(3);
        check("R4 ferr bit", status[3], 1);
        check("R4 fec one", fec, 1);
        check("R5 single error no oof", status[4], 0);
        fbchk(0); fbchk(0); fbchk(1); idle(3);
        check("R5 2 of 4 oof", status[4], 1);
        check("R5 ofc one", ofc, 1);
        check("R6 los on oof", status[5], 1);
        fbchk(0); fbchk(0); fbchk(0); idle(3); rd_clear();
        check("R5 oof gone", status[4], 0);
        check("R6 los held", status[5], 1);
        check("R10 ferr cleared", status[3], 0);
        sync_pulse();
        check("R6 los cleared by sync", status[5], 0);
        fbchk(1); fbchk(0); fbchk(0); fbchk(0); fbchk(1); idle(3); rd_clear();
        check("R5 short window misses", status[4], 0);
        check("R5 ofc still one", ofc, 1);
        sync_pulse();
        oof_win5 = 1;
        fbchk(1); fbchk(0); fbchk(0); fbchk(0); fbchk(1); idle(3); rd_clear();
        check("R5 long window hits", status[4], 1);
        check("R5 ofc two", ofc, 2);
        check("R4 fec six", fec, 6);
        sync_pulse();

        // R10/R11: burst read and mask
        fbchk(1); idle(2);
        st_rd = 1; st_burst = 1; cyc(); st_rd = 0; st_burst = 0; cyc();
        check("R10 burst read keeps", status[3], 1);
        mask = 8'h08; cyc();
        check("R11 irq on masked bit", irq, 1);
        mask = 8'h00; cyc();
        check("R11 mask clear drops irq", irq, 0);
        check("R11 status untouched", status[3], 1);
        rd_clear();

        // R8/R9: error counter saturation and write rules
        for (int i = 0; i < 12; i++) fbchk(1);
        idle(3);
        check("R8 fec saturated", fec, 15);
        check("R8 ecs bit", status[7], 1);
        rd_clear();
        check("R9 read keeps ecs", status[7], 1);
        mask = 8'h80; cyc();
        check("R11 irq from ecs", irq, 1);
        fec_wr = 1; wr_data = 8'h0f; cyc(); fec_wr = 0; idle(2);
        check("R9 all-ones write keeps ecs", status[7], 1);
        fec_wr = 1; wr_data = 8'h03; cyc(); fec_wr = 0; idle(2);
        check("R9 fec loaded", fec, 3);
        check("R9 ecs cleared", status[7], 0);
        check("R11 irq gone", irq, 0);
        mask = 8'h00;
        fec_wr = 1; wr_data = 8'h05; fb_chk = 1; fb_err = 1; cyc();
        fec_wr = 0; fb_chk = 0; fb_err = 0; idle(2);
        check("R9 write beats increment", fec, 5);

        // R7: violation counter saturation
        bpv = 1;
        for (int i = 0; i < 300; i++) cyc();
        bpv = 0; idle(2);
        check("R7 bvc saturated", bvc, 255);
        check("R7 bvs bit", status[6], 1);
        bvc_wr = 1; wr_data = 8'h10; cyc(); bvc_wr = 0; idle(2);
        check("R9 bvc loaded", bvc, 16);
        check("R9 bvs cleared", status[6], 0);
        bpv = 1; cyc(); bpv = 0; idle(2);
        check("R7 bvc counts after load", bvc, 17);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule